// File: doc/BRIEF.md
# Programmable-Format Serial Port with Error-Tagged Receive Words

This block is an asynchronous serial transmitter and receiver. Both directions use a single 16x oversampling tick from a programmable divider. Software sets up the line through three registers: a line-format register, a baud divisor and a control register. It then writes characters into a one-entry transmit holding register and reads received characters from a one-entry receive holding register. The character width is five to eight bits. Parity can be off, even or odd. One or two stop bits can be sent. Software can also hold the transmit line low to send a break.

Every received character comes back in one 12-bit word: the character sits in the low byte, and four error flags for that same character sit directly above it. Software therefore never has to match a separate status read to the character it belongs to. Status flags report whether the holding registers are full and whether the transmitter is busy. An interrupt group covers three events: receive data available, transmit holding empty and receive timeout. It has a raw view, an enable mask and a masked view, and `irq` is the OR of the masked view. A loopback control routes the transmitter straight into the receiver for self-test.

The register word index is `reg_addr`: 0 data, 1 line format, 2 divisor, 3 control, 4 status, 5 raw interrupts, 6 interrupt enable, 7 masked interrupts. A write to index 0 loads the transmit holding register. A read of index 0 (with `reg_rd` high) consumes the receive holding register. Reads are combinational on `reg_rdata`.

Top module: `fmt_uart`

## Requirements
- R1: With divisor value D in register 2, every transmitted bit lasts exactly 16*(D+1) clock cycles, and the oversample tick is never high on two consecutive cycles when D is nonzero.
- R2: Line-format bits 6:5 hold the character length minus five. The transmitter sends a low start bit, then the data bits least significant first, and ignores the data bits above the character length.
- R3: Received characters are right-aligned in data-word bits 7:0 with the unused upper bits reading zero. A low pulse on the receive input that is gone by the eighth oversample tick is discarded and produces no character.
- R4: Line-format bit 1 enables a parity bit after the data, and bit 2 selects even parity (odd when clear). A received parity mismatch sets bit 9 of that character's data word.
- R5: Line-format bit 3 selects two stop bits instead of one, and stop bits are driven high. A low first stop bit on receive sets bit 8 (framing error) of that character's data word.
- R6: While line-format bit 0 is set, `txd` is held low.
- R7: A received frame whose data, parity and stop bits are all low sets bit 11 (break) of its data word.
- R8: If a character completes while the previous one is unread, the new character replaces it and its data word has bit 10 (overrun) set.
- R9: Control bit 0 enables the port. While it is clear, no oversample ticks occur and a written character stays in the holding register without being sent.
- R10: Control bit 6 feeds the transmitted frame into the receiver and holds `txd` high.
- R11: Status bit 7 is set when the transmit holding register is empty, bit 4 is set when no received character is waiting, and bit 3 is set while a frame is being shifted out. Status reads 0x0090 after reset, and reading the data word sets bit 4 again.
- R12: Raw interrupt bit 0 is receive data available, bit 1 is transmit holding empty and bit 3 is receive timeout. The masked register equals raw AND enable, and `irq` is high exactly when the masked value is nonzero.
- R13: Receive timeout sets once a character has waited unread for 32 bit periods with no new start bit. A read of the data word clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes data at index 0) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on reg_addr |
| rxd | input | 1 | Serial receive input |
| txd | output | 1 | Serial transmit output |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- the oversample tick is a single-cycle pulse, and no tick occurs while the port is disabled;
- a data read clears data-available;
- a pending timeout always has an unread character behind it;
- overrun is never flagged on a character that arrived into an empty register;
- the transmit line is high whenever a frame ends without a forced break.

Other behaviour only the bench scenarios can show: the exact bit timing and order on `txd`, the parity polarity, and the error bits attached to deliberately malformed frames. The same holds for glitch rejection, the 32-bit-period timeout window and the interplay of the enable mask with `irq`.

// File: rtl/fmt_uart_pkg.sv
package fmt_uart_pkg;

  localparam int unsigned OSR = 16;

  localparam logic [2:0] IX_DATA = 3'd0;
  localparam logic [2:0] IX_FMT  = 3'd1;
  localparam logic [2:0] IX_DIV  = 3'd2;
  localparam logic [2:0] IX_CTL  = 3'd3;
  localparam logic [2:0] IX_STAT = 3'd4;
  localparam logic [2:0] IX_RAW  = 3'd5;
  localparam logic [2:0] IX_IEN  = 3'd6;
  localparam logic [2:0] IX_MSK  = 3'd7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  typedef struct packed {
    logic [1:0] wlen;      // character length minus five
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } fmt_t;

endpackage

// File: rtl/fmt_uart_baud.sv
module fmt_uart_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      tick  = 1'b1;
      cnt_d = div;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx
  import fmt_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  output logic       take,
  output logic       line,
  output logic       busy
);

  phase_t     ph_q, ph_d;
  logic [3:0] os_q, os_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       par_q, par_d;
  logic [2:0] last_bit;

  wire unused_fmt = fmt.brk;

  assign last_bit = {1'b0, fmt.wlen} + 3'd4;
  assign busy     = (ph_q != PH_IDLE);

  always_comb begin
    ph_d  = ph_q;
    os_d  = os_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    par_d = par_q;
    take  = 1'b0;
    line  = 1'b1;
    case (ph_q)
      PH_IDLE: begin
        if (tick && hold_full) begin
          take  = 1'b1;
          ph_d  = PH_START;
          os_d  = 4'd0;
          sh_d  = hold_data;
          par_d = !fmt.even;
        end
      end
      PH_START: begin
        line = 1'b0;
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            ph_d  = PH_DATA;
            bit_d = 3'd0;
          end
        end
      end
      PH_DATA: begin
        line = sh_q[0];
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            par_d = par_q ^ sh_q[0];
            sh_d  = {1'b0, sh_q[7:1]};
            if (bit_q == last_bit) begin
              ph_d  = fmt.par_en ? PH_PAR : PH_STOP;
              bit_d = 3'd0;
            end else begin
              bit_d = bit_q + 3'd1;
            end
          end
        end
      end
      PH_PAR: begin
        line = par_q;
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            ph_d  = PH_STOP;
            bit_d = 3'd0;
          end
        end
      end
      PH_STOP: begin
        line = 1'b1;
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            if (fmt.two_stop && (bit_q == 3'd0)) bit_d = 3'd1;
            else                                 ph_d  = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      os_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      os_q  <= os_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

endmodule

// File: rtl/fmt_uart_rx.sv
module fmt_uart_rx
  import fmt_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       rx_in,
  output logic       done,
  output logic [7:0] char_o,
  output logic       fe,
  output logic       pe,
  output logic       brk,
  output logic       idle,
  output logic       start_det
);

  phase_t     ph_q, ph_d;
  logic [3:0] os_q, os_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] dat_q, dat_d;
  logic       acc_q, acc_d;
  logic       zero_q, zero_d;
  logic [2:0] last_bit;

  wire unused_fmt = ^{fmt.brk, fmt.two_stop};

  assign last_bit = {1'b0, fmt.wlen} + 3'd4;
  assign idle     = (ph_q == PH_IDLE);
  assign char_o   = dat_q;

  always_comb begin
    ph_d      = ph_q;
    os_d      = os_q;
    bit_d     = bit_q;
    dat_d     = dat_q;
    acc_d     = acc_q;
    zero_d    = zero_q;
    done      = 1'b0;
    fe        = 1'b0;
    pe        = 1'b0;
    brk       = 1'b0;
    start_det = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (tick && !rx_in) begin
          ph_d      = PH_START;
          os_d      = 4'd0;
          start_det = 1'b1;
        end
      end
      PH_START: begin
        if (tick) begin
          if (os_q == 4'd7) begin
            if (!rx_in) begin
              ph_d   = PH_DATA;
              os_d   = 4'd0;
              bit_d  = 3'd0;
              dat_d  = '0;
              acc_d  = 1'b0;
              zero_d = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end else begin
            os_d = os_q + 4'd1;
          end
        end
      end
      PH_DATA: begin
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            dat_d[bit_q] = rx_in;
            acc_d        = acc_q ^ rx_in;
            zero_d       = zero_q & !rx_in;
            if (bit_q == last_bit) begin
              ph_d  = fmt.par_en ? PH_PAR : PH_STOP;
              bit_d = 3'd0;
            end else begin
              bit_d = bit_q + 3'd1;
            end
          end
        end
      end
      PH_PAR: begin
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            acc_d  = acc_q ^ rx_in;
            zero_d = zero_q & !rx_in;
            ph_d   = PH_STOP;
          end
        end
      end
      PH_STOP: begin
        if (tick) begin
          os_d = os_q + 4'd1;
          if (os_q == 4'd15) begin
            done = 1'b1;
            fe   = !rx_in;
            brk  = zero_q & !rx_in;
            pe   = fmt.par_en & (acc_q != !fmt.even);
            ph_d = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      os_q   <= '0;
      bit_q  <= '0;
      dat_q  <= '0;
      acc_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      dat_q  <= dat_d;
      acc_q  <= acc_d;
      zero_q <= zero_d;
    end
  end

endmodule

// File: rtl/fmt_uart.sv
module fmt_uart
  import fmt_uart_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int TO_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);

  localparam int RW       = 16;
  localparam int TO_TICKS = TO_BITS * OSR;
  localparam int TO_W     = $clog2(TO_TICKS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // configuration and holding state
  fmt_t             fmt_q, fmt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             ctl_en_q, ctl_en_d;
  logic             ctl_lbe_q, ctl_lbe_d;
  logic [3:0]       ien_q, ien_d;
  logic [7:0]       thr_q, thr_d;
  logic             thr_full_q, thr_full_d;
  logic [11:0]      rxh_q, rxh_d;
  logic             rx_full_q, rx_full_d;
  logic             rto_q, rto_d;
  logic [TO_W-1:0]  to_cnt_q, to_cnt_d;
  logic [1:0]       rxs_q;

  logic       baud_tick;
  logic       tx_take, tx_line, tx_busy;
  logic       rx_in, rx_done, rx_fe, rx_pe, rx_brk, rx_idle, rx_start;
  logic [7:0] rx_char;
  logic       wr_data, rd_data;
  logic [3:0] raw, masked;
  logic       line_out;

  wire unused_wbits = ^{reg_wdata[15:DIV_W], reg_wdata[4], reg_wdata[5]};

  assign wr_data = reg_wr && (reg_addr == IX_DATA);
  assign rd_data = reg_rd && (reg_addr == IX_DATA);

  fmt_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_i),
    .en   (ctl_en_q),
    .div  (div_q),
    .tick (baud_tick)
  );

  fmt_uart_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (baud_tick),
    .fmt      (fmt_q),
    .hold_full(thr_full_q),
    .hold_data(thr_q),
    .take     (tx_take),
    .line     (tx_line),
    .busy     (tx_busy)
  );

  assign line_out = fmt_q.brk ? 1'b0 : tx_line;
  assign txd      = ctl_lbe_q ? 1'b1 : line_out;
  assign rx_in    = ctl_lbe_q ? line_out : rxs_q[1];

  fmt_uart_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (baud_tick),
    .fmt      (fmt_q),
    .rx_in    (rx_in),
    .done     (rx_done),
    .char_o   (rx_char),
    .fe       (rx_fe),
    .pe       (rx_pe),
    .brk      (rx_brk),
    .idle     (rx_idle),
    .start_det(rx_start)
  );

  // next-state logic
  always_comb begin
    fmt_d      = fmt_q;
    div_d      = div_q;
    ctl_en_d   = ctl_en_q;
    ctl_lbe_d  = ctl_lbe_q;
    ien_d      = ien_q;
    thr_d      = thr_q;
    thr_full_d = thr_full_q;
    rxh_d      = rxh_q;
    rx_full_d  = rx_full_q;
    rto_d      = rto_q;
    to_cnt_d   = to_cnt_q;

    if (tx_take) thr_full_d = 1'b0;

    if (reg_wr) begin
      case (reg_addr)
        IX_DATA: begin
          thr_d      = reg_wdata[7:0];
          thr_full_d = 1'b1;
        end
        IX_FMT: begin
          fmt_d.wlen     = reg_wdata[6:5];
          fmt_d.two_stop = reg_wdata[3];
          fmt_d.even     = reg_wdata[2];
          fmt_d.par_en   = reg_wdata[1];
          fmt_d.brk      = reg_wdata[0];
        end
        IX_DIV: div_d = reg_wdata[DIV_W-1:0];
        IX_CTL: begin
          ctl_en_d  = reg_wdata[0];
          ctl_lbe_d = reg_wdata[6];
        end
        IX_IEN: ien_d = {reg_wdata[3], 1'b0, reg_wdata[1:0]};
        default: ;
      endcase
    end

    if (rd_data) begin
      rx_full_d = 1'b0;
      rto_d     = 1'b0;
    end

    if (rx_done) begin
      rxh_d     = {rx_brk, rx_full_d, rx_pe, rx_fe, rx_char};
      rx_full_d = 1'b1;
      rto_d     = 1'b0;
    end

    if (rx_full_q && rx_idle && !rx_start && !rto_q && !rd_data) begin
      if (baud_tick) begin
        if (to_cnt_q == TO_W'(TO_TICKS - 1)) begin
          rto_d    = 1'b1;
          to_cnt_d = '0;
        end else begin
          to_cnt_d = to_cnt_q + 1'b1;
        end
      end
    end else begin
      to_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      fmt_q      <= '0;
      div_q      <= '0;
      ctl_en_q   <= 1'b0;
      ctl_lbe_q  <= 1'b0;
      ien_q      <= '0;
      thr_q      <= '0;
      thr_full_q <= 1'b0;
      rxh_q      <= '0;
      rx_full_q  <= 1'b0;
      rto_q      <= 1'b0;
      to_cnt_q   <= '0;
      rxs_q      <= 2'b11;
    end else begin
      fmt_q      <= fmt_d;
      div_q      <= div_d;
      ctl_en_q   <= ctl_en_d;
      ctl_lbe_q  <= ctl_lbe_d;
      ien_q      <= ien_d;
      thr_q      <= thr_d;
      thr_full_q <= thr_full_d;
      rxh_q      <= rxh_d;
      rx_full_q  <= rx_full_d;
      rto_q      <= rto_d;
      to_cnt_q   <= to_cnt_d;
      rxs_q      <= {rxs_q[0], rxd};
    end
  end

  assign raw    = {rto_q, 1'b0, !thr_full_q, rx_full_q};
  assign masked = raw & ien_q;
  assign irq    = |masked;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_DATA: reg_rdata = {4'b0, rxh_q};
      IX_FMT:  reg_rdata = {9'b0, fmt_q.wlen, 1'b0, fmt_q.two_stop,
                            fmt_q.even, fmt_q.par_en, fmt_q.brk};
      IX_DIV:  reg_rdata = {{(RW-DIV_W){1'b0}}, div_q};
      IX_CTL:  reg_rdata = {9'b0, ctl_lbe_q, 5'b0, ctl_en_q};
      IX_STAT: reg_rdata = {8'b0, !thr_full_q, 2'b0, !rx_full_q, tx_busy, 3'b0};
      IX_RAW:  reg_rdata = {12'b0, raw};
      IX_IEN:  reg_rdata = {12'b0, ien_q};
      IX_MSK:  reg_rdata = {12'b0, masked};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fmt_uart_chk.sv
module fmt_uart_chk
  import fmt_uart_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_i,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic             baud_tick,
  input logic [DIV_W-1:0] div_q,
  input logic             ctl_en_q,
  input logic             rx_done,
  input logic             rx_full_q,
  input logic [11:0]      rxh_q,
  input logic             rto_q,
  input logic             tx_busy,
  input logic             txd,
  input fmt_t             fmt_q
);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    (baud_tick && (div_q != '0)) |=> !baud_tick); // R1

  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_i)
    !ctl_en_q |-> !baud_tick); // R9

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_rd && (reg_addr == IX_DATA) && !rx_done) |=> !rx_full_q); // R11

  AST_TIMEOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_i)
    rto_q |-> rx_full_q); // R13

  AST_NO_FALSE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_done && !rx_full_q) |=> !rxh_q[10]); // R8

  AST_FRAME_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(tx_busy) |-> (txd || fmt_q.brk)); // R5

endmodule

bind fmt_uart fmt_uart_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .baud_tick(baud_tick),
  .div_q    (div_q),
  .ctl_en_q (ctl_en_q),
  .rx_done  (rx_done),
  .rx_full_q(rx_full_q),
  .rxh_q    (rxh_q),
  .rto_q    (rto_q),
  .tx_busy  (tx_busy),
  .txd      (txd),
  .fmt_q    (fmt_q)
);

// File: tb/fmt_uart_bench.sv
module fmt_uart_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        rxd;
  logic        txd;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int bitlen = 16;

  logic [11:0] exp_q[$];

  fmt_uart u_fmt_uart (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rxd      (rxd),
    .txd      (txd),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(3'd2, 16'(d));
    bitlen = 16 * (d + 1);
  endtask

  // drive one frame on rxd; pmode 0 none, 1 correct parity, 2 wrong parity
  task automatic drive_frame(input logic [7:0] d, input int nbits, input int pmode,
                             input bit even, input bit stop_v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nbits; i++) p = p ^ d[i];
    if (!even) p = ~p;
    if (pmode == 2) p = ~p;
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = d[i];
      repeat (bitlen) @(negedge clk);
    end
    if (pmode != 0) begin
      rxd = p;
      repeat (bitlen) @(negedge clk);
    end
    rxd = stop_v;
    repeat (bitlen) @(negedge clk);
    rxd = 1'b1;
    repeat (bitlen) @(negedge clk);
  endtask

  // follow a frame on txd and compare each bit at its midpoint
  task automatic tx_expect(input string req, input logic [7:0] d, input int nbits,
                           input bit par_en, input bit even, input int nstop);
    logic p;
    logic [15:0] s;
    int guard;
    p = 1'b0;
    for (int i = 0; i < nbits; i++) p = p ^ d[i];
    if (!even) p = ~p;
    guard = 0;
    while (txd !== 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (bitlen / 2) @(negedge clk);
    check({req, " start bit"}, {15'b0, txd}, 16'h0000);
    rd(3'd4, s);
    check("R11 busy while shifting", s & 16'h0008, 16'h0008);
    repeat (bitlen - 2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      check({req, " data bit"}, {15'b0, txd}, {15'b0, d[i]});
      repeat (bitlen) @(negedge clk);
    end
    if (par_en) begin
      check("R4 parity bit", {15'b0, txd}, {15'b0, p});
      repeat (bitlen) @(negedge clk);
    end
    for (int i = 0; i < nstop; i++) begin
      check("R5 stop bit", {15'b0, txd}, 16'h0001);
      repeat (bitlen) @(negedge clk);
    end
  endtask

  // scoreboard monitor: wait for a character, pop the expected word and compare
  task automatic mon_pop(input string req);
    logic [15:0] s, d;
    logic [11:0] e;
    int guard;
    guard = 0;
    s = 16'h0010;
    while (s[4] && guard < 400) begin
      rd(3'd4, s);
      if (s[4]) repeat (8) @(negedge clk);
      guard++;
    end
    rd(3'd0, d);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 12'hFFF;
    check(req, d, {4'b0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int lb_txd_low;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_addr  = 3'd0;
    reg_wdata = 16'h0;
    rxd       = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(3'd4, v); check("R11 reset status", v, 16'h0090);
    rd(3'd5, v); check("R12 reset raw", v, 16'h0002);
    check("R12 reset irq", {15'b0, irq}, 16'h0000);
    check("R6 reset txd idle", {15'b0, txd}, 16'h0001);

    // transmit 8N1 at divisor 0
    set_div(0);
    wr(3'd1, 16'h0060);
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h00A5);
    tx_expect("R2 8N1", 8'hA5, 8, 1'b0, 1'b0, 1);

    // divisor 1, 7 bits even parity two stops
    set_div(1);
    wr(3'd1, 16'h004E);
    wr(3'd0, 16'h00BC);
    tx_expect("R1 R2 7E2 div1", 8'h3C, 7, 1'b1, 1'b1, 2);
    set_div(0);

    // loopback 8N1
    wr(3'd1, 16'h0060);
    wr(3'd3, 16'h0041);
    exp_q.push_back(12'h05A);
    wr(3'd0, 16'h005A);
    lb_txd_low = 0;
    repeat (200) begin
      @(negedge clk);
      if (txd !== 1'b1) lb_txd_low++;
    end
    check("R10 txd held high in loopback", 16'(lb_txd_low), 16'h0000);
    mon_pop("R10 loopback 8N1");

    // loopback 5 bits odd parity: upper bits dropped
    wr(3'd1, 16'h0002);
    exp_q.push_back(12'h013);
    wr(3'd0, 16'h00F3);
    mon_pop("R3 loopback 5O1 upper zero");
    rd(3'd4, v); check("R11 data read empties", v & 16'h0010, 16'h0010);
    rd(3'd5, v); check("R12 raw rx bit clear", v & 16'h0001, 16'h0000);

    // external receive: parity errors
    wr(3'd3, 16'h0001);
    wr(3'd1, 16'h0066);
    exp_q.push_back(12'h281);
    drive_frame(8'h81, 8, 2, 1'b1, 1'b1);
    mon_pop("R4 wrong parity flagged");
    exp_q.push_back(12'h081);
    drive_frame(8'h81, 8, 1, 1'b1, 1'b1);
    mon_pop("R4 good parity clean");

    // framing error
    wr(3'd1, 16'h0060);
    exp_q.push_back(12'h142);
    drive_frame(8'h42, 8, 0, 1'b0, 1'b0);
    mon_pop("R5 framing error");

    // break
    exp_q.push_back(12'h900);
    drive_frame(8'h00, 8, 0, 1'b0, 1'b0);
    mon_pop("R7 break detected");

    // glitch shorter than half a bit
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitlen) @(negedge clk);
    rd(3'd4, v); check("R3 glitch rejected", v & 16'h0010, 16'h0010);

    // overrun
    drive_frame(8'h11, 8, 0, 1'b0, 1'b1);
    exp_q.push_back(12'h422);
    drive_frame(8'h22, 8, 0, 1'b0, 1'b1);
    mon_pop("R8 overrun replaces");

    // receive timeout and interrupts
    drive_frame(8'h33, 8, 0, 1'b0, 1'b1);
    repeat (400 - bitlen) @(negedge clk);
    rd(3'd5, v); check("R13 no timeout yet", v & 16'h0008, 16'h0000);
    repeat (300) @(negedge clk);
    rd(3'd5, v); check("R13 timeout raised", v, 16'h000B);
    wr(3'd6, 16'h0008);
    rd(3'd7, v); check("R12 masked timeout", v, 16'h0008);
    check("R12 irq on timeout", {15'b0, irq}, 16'h0001);
    exp_q.push_back(12'h033);
    mon_pop("R13 timed-out data");
    rd(3'd5, v); check("R13 read clears timeout", v & 16'h0008, 16'h0000);
    check("R12 irq drops", {15'b0, irq}, 16'h0000);
    wr(3'd6, 16'h0002);
    rd(3'd7, v); check("R12 masked tx empty", v, 16'h0002);
    check("R12 irq on tx empty", {15'b0, irq}, 16'h0001);
    wr(3'd6, 16'h0000);

    // forced break output
    wr(3'd1, 16'h0061);
    repeat (3) @(negedge clk);
    check("R6 break drives low", {15'b0, txd}, 16'h0000);
    wr(3'd1, 16'h0060);
    repeat (3) @(negedge clk);
    check("R6 break released", {15'b0, txd}, 16'h0001);

    // disabled port holds the character
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0077);
    repeat (200) @(negedge clk);
    rd(3'd4, v); check("R9 held while disabled", v & 16'h0088, 16'h0000);
    check("R9 line idle while disabled", {15'b0, txd}, 16'h0001);
    wr(3'd3, 16'h0001);
    tx_expect("R9 sent after enable", 8'h77, 8, 1'b0, 1'b0, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule